// File: doc/BRIEF.md
# Programmable GPIO Port Cell

An eight-bit general-purpose I/O bank controlled through a small synchronous register port. Each bit has a direction control and an inversion control. All bits share one data register. A bit set as an output drives its pin from the stored data value, optionally inverted. A bit set as an input ignores writes. Reading that bit returns the synchronized pin level, optionally inverted, captured at the moment of the read.

Pin inputs pass through a two-stage synchronizer before anything uses them. The block also gives downstream wake or interrupt logic two outputs. The first is a per-bit qualifier that is high only for input bits. The second is a polarity-corrected input level that is held low for any bit driven as an output.

Top module: `gpio_bank`

## Requirements
- R1: After synchronous reset, every bit is an input with no inversion and the data register is clear. At that point `pin_oe`=0x00, `pin_out`=0x00, `reg_rdata`=0x00, `in_qual`=0xFF, and reads at offsets 0, 1 and 2 return 0x00.
- R2: Offset 1 holds the direction register (bit = 1 means output). It reads back the last value written. `pin_oe` equals it from the cycle after the write.
- R3: Offset 2 holds the inversion register and reads back the last value written. Offset 3 reads 0x00, and a write there changes no register.
- R4: For an output bit, `pin_out` is the stored data bit XOR its inversion bit. For an input bit, `pin_out` is 0.
- R5: A write to offset 0 updates only the bits currently set as outputs. The stored value of input bits stays unchanged, which shows once such a bit is later turned to an output.
- R6: A read of offset 0 returns the stored data bit for output bits, whatever the pin level.
- R7: A read of offset 0 returns the synchronized pin value XOR the inversion bit for input bits.
- R8: Read data appears on `reg_rdata` on the cycle after `reg_rd_en` is sampled. It holds until the next read.
- R9: A pin change sampled at clock edge k is first visible in a read sampled at edge k+2. A read sampled at edge k+1 still returns the old level.
- R10: `in_qual` is the inverse of the direction register. `evt_lvl` is the synchronized pin XOR inversion for input bits and 0 for output bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register offset (0 data, 1 direction, 2 inversion) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| pin_in | input | 8 | Pin levels from the pads |
| pin_out | output | 8 | Values driven to the pads |
| pin_oe | output | 8 | Per-bit output enable |
| in_qual | output | 8 | High for bits in input mode |
| evt_lvl | output | 8 | Polarity-corrected input level, masked for outputs |

## Verification
A wrong direction bit shows at once on `pin_oe` and `in_qual`, in the cycle after the offending write. A wrong data or inversion bit appears on `pin_out` in that same cycle if the bit is an output. If the bit is an input, the error stays hidden until the bit is turned to an output or read back. A lost input write mask is invisible until the bit changes direction, so the bench writes to input bits, flips them to outputs and reads them back. A synchronizer of the wrong depth shifts the first read that sees a pin change by one cycle, and the bench probes that exact boundary.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_DATA = 2'd0,
        SEL_DIR  = 2'd1,
        SEL_POL  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    function automatic reg_sel_e decode_sel(input logic [ADDR_W-1:0] addr);
        case (addr)
            2'd0:    return SEL_DATA;
            2'd1:    return SEL_DIR;
            2'd2:    return SEL_POL;
            default: return SEL_NONE;
        endcase
    endfunction

    function automatic logic mix_bit(input logic dir_b, input logic stored_b,
                                     input logic live_b);
        return dir_b ? stored_b : live_b;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage[s] <= '0;
                    else     stage[s] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage[s] <= '0;
                    else     stage[s] <= stage[s-1];
                end
            end
        end
    endgenerate

    assign q = stage[STAGES-1];
endmodule

// File: rtl/gpio_cfg.sv
module gpio_cfg
    import gpio_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  reg_sel_e     sel,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] dir,
    output logic [W-1:0] pol,
    output logic [W-1:0] data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            dir <= '0;
        end else if (wr_en && sel == SEL_DIR) begin
            dir <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pol <= '0;
        end else if (wr_en && sel == SEL_POL) begin
            pol <= wdata;
        end
    end

    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_data
            always_ff @(posedge clk) begin
                if (rst) begin
                    data[i] <= 1'b0;
                end else if (wr_en && sel == SEL_DATA && dir[i]) begin
                    data[i] <= wdata[i];
                end
            end
        end
    endgenerate
endmodule

// File: rtl/gpio_rdpath.sv
module gpio_rdpath
    import gpio_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         rd_en,
    input  reg_sel_e     sel,
    input  logic [W-1:0] dir,
    input  logic [W-1:0] pol,
    input  logic [W-1:0] data,
    input  logic [W-1:0] live,
    output logic [W-1:0] rdata
);
    logic [W-1:0] data_view;
    logic [W-1:0] rd_next;

    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_view
            assign data_view[i] = mix_bit(dir[i], data[i], live[i] ^ pol[i]);
        end
    endgenerate

    always_comb begin
        case (sel)
            SEL_DATA: rd_next = data_view;
            SEL_DIR:  rd_next = dir;
            SEL_POL:  rd_next = pol;
            default:  rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata <= '0;
        else if (rd_en) rdata <= rd_next;
    end
endmodule

// File: rtl/gpio_pinside.sv
module gpio_pinside #(
    parameter int W = 8
) (
    input  logic [W-1:0] dir,
    input  logic [W-1:0] pol,
    input  logic [W-1:0] data,
    input  logic [W-1:0] live,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_oe,
    output logic [W-1:0] in_qual,
    output logic [W-1:0] evt_lvl
);
    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_bit
            assign pin_oe[i]  = dir[i];
            assign pin_out[i] = dir[i] & (data[i] ^ pol[i]);
            assign in_qual[i] = ~dir[i];
            assign evt_lvl[i] = ~dir[i] & (live[i] ^ pol[i]);
        end
    endgenerate
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_pkg::*;
#(
    parameter int W           = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_en,
    input  logic              reg_rd_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [W-1:0]      reg_wdata,
    output logic [W-1:0]      reg_rdata,
    input  logic [W-1:0]      pin_in,
    output logic [W-1:0]      pin_out,
    output logic [W-1:0]      pin_oe,
    output logic [W-1:0]      in_qual,
    output logic [W-1:0]      evt_lvl
);
    reg_sel_e     sel;
    logic [W-1:0] dir_r;
    logic [W-1:0] pol_r;
    logic [W-1:0] data_r;
    logic [W-1:0] live;

    assign sel = decode_sel(reg_addr);

    gpio_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (live)
    );

    gpio_cfg #(.W(W)) u_cfg (
        .clk   (clk),
        .rst   (rst),
        .wr_en (reg_wr_en),
        .sel   (sel),
        .wdata (reg_wdata),
        .dir   (dir_r),
        .pol   (pol_r),
        .data  (data_r)
    );

    gpio_rdpath #(.W(W)) u_rd (
        .clk   (clk),
        .rst   (rst),
        .rd_en (reg_rd_en),
        .sel   (sel),
        .dir   (dir_r),
        .pol   (pol_r),
        .data  (data_r),
        .live  (live),
        .rdata (reg_rdata)
    );

    gpio_pinside #(.W(W)) u_pin (
        .dir     (dir_r),
        .pol     (pol_r),
        .data    (data_r),
        .live    (live),
        .pin_out (pin_out),
        .pin_oe  (pin_oe),
        .in_qual (in_qual),
        .evt_lvl (evt_lvl)
    );
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         reg_wr_en,
    input logic         reg_rd_en,
    input logic [1:0]   reg_addr,
    input logic [W-1:0] reg_wdata,
    input logic [W-1:0] reg_rdata,
    input logic [W-1:0] pin_in,
    input logic [W-1:0] pin_out,
    input logic [W-1:0] pin_oe,
    input logic [W-1:0] in_qual,
    input logic [W-1:0] evt_lvl
);
    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (pin_oe == '0 && reg_rdata == '0));

    a_r2_oe_follows_write: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_en && reg_addr == 2'd1) |=> (pin_oe == $past(reg_wdata)));

    a_r4_input_pin_quiet: assert property (@(posedge clk) disable iff (rst)
        (pin_out & ~pin_oe) == '0);

    a_r8_rdata_holds: assert property (@(posedge clk) disable iff (rst)
        (!$past(reg_rd_en) && !$past(rst)) |-> $stable(reg_rdata));

    a_r10_qual_inverse: assert property (@(posedge clk) disable iff (rst)
        in_qual == ~pin_oe);

    a_r10_evt_masked: assert property (@(posedge clk) disable iff (rst)
        (evt_lvl & pin_oe) == '0);

    logic unused_ok;
    assign unused_ok = ^pin_in;
endmodule

bind gpio_bank gpio_bank_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr_en (reg_wr_en),
    .reg_rd_en (reg_rd_en),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .in_qual   (in_qual),
    .evt_lvl   (evt_lvl)
);

// File: tb/sim_gpio_bank.sv
module sim_gpio_bank;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         reg_wr_en = 1'b0;
    logic         reg_rd_en = 1'b0;
    logic [1:0]   reg_addr = '0;
    logic [W-1:0] reg_wdata = '0;
    logic [W-1:0] reg_rdata;
    logic [W-1:0] pin_in = '0;
    logic [W-1:0] pin_out;
    logic [W-1:0] pin_oe;
    logic [W-1:0] in_qual;
    logic [W-1:0] evt_lvl;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    logic [W-1:0] m_dir  = '0;
    logic [W-1:0] m_pol  = '0;
    logic [W-1:0] m_data = '0;

    always #2 clk = ~clk;

    gpio_bank #(.W(W), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .in_qual(in_qual), .evt_lvl(evt_lvl)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            fails = fails + 1;
            $display("FAIL watchdog: run hung, actual=%0d expected<150000", cycles);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] exp_read(input logic [1:0] a);
        case (a)
            2'd0:    return (m_dir & m_data) | (~m_dir & (pin_in ^ m_pol));
            2'd1:    return m_dir;
            2'd2:    return m_pol;
            default: return '0;
        endcase
    endfunction

    function automatic logic [W-1:0] exp_pin_out();
        return m_dir & (m_data ^ m_pol);
    endfunction

    // all tasks are entered at a falling edge and leave at one
    task automatic wr(input logic [1:0] a, input logic [W-1:0] v);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr_en = 1'b0;
        case (a)
            2'd0: m_data = (m_data & ~m_dir) | (v & m_dir);
            2'd1: m_dir = v;
            2'd2: m_pol = v;
            default: ;
        endcase
    endtask

    task automatic rd(input logic [1:0] a, output logic [W-1:0] v);
        reg_rd_en = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd_en = 1'b0;
        v = reg_rdata;
    endtask

    task automatic set_pin(input logic [W-1:0] v);
        pin_in = v;
        repeat (2) @(negedge clk);
    endtask

    task automatic chk_pins(input string req);
        chk({req, " pin_out"}, pin_out, exp_pin_out());
        chk({req, " pin_oe"}, pin_oe, m_dir);
        chk({req, " in_qual"}, in_qual, ~m_dir);
        chk({req, " evt_lvl"}, evt_lvl, ~m_dir & (pin_in ^ m_pol));
    endtask

    initial begin
        logic [W-1:0] v;
        logic [W-1:0] held;
        int unused_seed;
        unused_seed = $urandom(32'h1A2B);

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 pin_oe", pin_oe, 8'h00);
        chk("R1 pin_out", pin_out, 8'h00);
        chk("R1 rdata", reg_rdata, 8'h00);
        chk("R1 in_qual", in_qual, 8'hFF);
        rd(2'd0, v); chk("R1 data reg", v, 8'h00);
        rd(2'd1, v); chk("R1 dir reg", v, 8'h00);
        rd(2'd2, v); chk("R1 pol reg", v, 8'h00);

        // R2 direction readback and output enable
        wr(2'd1, 8'h3C);
        chk("R2 pin_oe", pin_oe, 8'h3C);
        rd(2'd1, v); chk("R2 dir readback", v, 8'h3C);

        // R3 inversion readback, offset 3 inert
        wr(2'd2, 8'h96);
        rd(2'd2, v); chk("R3 pol readback", v, 8'h96);
        wr(2'd3, 8'hFF);
        rd(2'd3, v); chk("R3 offset 3 reads zero", v, 8'h00);
        rd(2'd1, v); chk("R3 dir untouched by offset 3", v, 8'h3C);
        rd(2'd2, v); chk("R3 pol untouched by offset 3", v, 8'h96);

        // R5 writes to input bits ignored
        wr(2'd2, 8'h00);
        wr(2'd1, 8'h0F);
        wr(2'd0, 8'hFF);
        wr(2'd1, 8'hFF);
        rd(2'd0, v); chk("R5 input bits kept old data", v, 8'h0F);
        chk("R5 pin_out after flip", pin_out, 8'h0F);

        // R4 / R6 outputs: inversion on pin, readback ignores pin
        wr(2'd0, 8'hA5);
        wr(2'd2, 8'hFF);
        set_pin(8'h00);
        chk("R4 inverted drive", pin_out, 8'h5A);
        rd(2'd0, v); chk("R6 output read ignores pin", v, 8'hA5);

        // R7 inputs with inversion
        wr(2'd1, 8'h00);
        wr(2'd2, 8'hF0);
        set_pin(8'h33);
        rd(2'd0, v); chk("R7 input read", v, 8'hC3);
        chk_pins("R10");

        // R8 rdata holds without a read
        held = reg_rdata;
        set_pin(8'hCC);
        repeat (3) @(negedge clk);
        chk("R8 rdata held", reg_rdata, held);

        // R9 synchronizer boundary, no inversion
        wr(2'd2, 8'h00);
        set_pin(8'h00);
        repeat (2) @(negedge clk);
        pin_in = 8'h5E;
        @(negedge clk);
        rd(2'd0, v); chk("R9 read at k+1 still old", v, 8'h00);
        rd(2'd0, v); chk("R9 read at k+2 sees new", v, 8'h5E);

        // random mix
        for (int n = 0; n < 400; n++) begin
            int op;
            logic [1:0] a;
            op = $urandom_range(0, 3);
            a  = 2'($urandom_range(0, 3));
            case (op)
                0: wr(a, 8'($urandom()));
                1: set_pin(8'($urandom()));
                default: begin
                    logic [W-1:0] e;
                    e = exp_read(a);
                    rd(a, v);
                    chk(a == 2'd0 ? "R6/R7 random data read" : "R2/R3 random reg read", v, e);
                end
            endcase
            repeat (2) @(negedge clk);
            chk_pins("R4/R10 random");
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule